// File: doc/BRIEF.md
# Biphase Mark Line Decoder

This block turns a single-wire biphase mark coded line into a recovered data bit, a one-cycle sampling strobe and an active-low frame select, so that a plain SPI client can shift the bits in. Every bit cell opens with a line transition. A cell that carries a one has a second transition half way through. A cell that carries a zero has no second transition.

The decoder runs on a local clock at eight times the nominal bitrate. A phase counter restarts on each accepted cell boundary. At phase 5, about three quarters into the cell, the line is sampled and compared with the level taken at the same point of the previous cell. Once the counter has passed that point, an arming flag lets the next transition restart it. Transitions seen earlier in the cell, such as the mid-cell ones, are ignored. The counter waits at its last phase for a late boundary, which gives tolerance to a transmitter that runs slow or fast. A silence timer that runs while the counter waits closes the frame when the line stops toggling.

Top module: `bmc_line_decoder`

## Requirements
- R1: After reset, frameSelN is 1, dataOut is 0 and clkStrobe is 0.
- R2: While idle, a transition of rxIn in either direction starts a frame. frameSelN goes low after the third rising clock edge that follows the change of rxIn (two synchroniser stages plus one register).
- R3: For each accepted cell boundary, clkStrobe is high for exactly one cycle. It is first seen high after the 10th rising edge that follows the boundary change of rxIn. dataOut changes only on the edge one cycle before a strobe.
- R4: The first bit reported in every frame is 0.
- R5: Every later bit is 1 when the line level at its sample point (phase 5) equals the level at the previous sample point, and 0 when the two levels differ.
- R6: A transition that arrives before phase 5 of the current cell does not restart the phase counter and does not change the decoded bits or the strobe timing. This covers mid-cell transitions and short glitch pairs.
- R7: The phase counter holds at 7 until a validated transition arrives. A validated transition at phase 6 or 7 restarts it, so streams with cell lengths from 7 to 10 clock cycles decode correctly.
- R8: Once the counter holds at 7 and 56 clock cycles pass with no validated transition, frameSelN goes high. With no further input this happens after the 66th rising edge that follows the last boundary change. Every validated transition clears the silence time.
- R9: After a frame ends, the decoder is idle: no strobe occurs while frameSelN is high, and the next transition starts a new frame whose first bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, eight times the bitrate |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Biphase mark coded line |
| dataOut | output | 1 | Recovered data bit |
| clkStrobe | output | 1 | One-cycle strobe, data is stable while it is high |
| frameSelN | output | 1 | Active-low frame select, high when no frame is in progress |

## Verification
The assertions assume that rxIn is held low through reset, and that the first transition of each frame is the opening boundary of a zero cell. They also assume that every level the line takes lasts at least one clock cycle, and that cell lengths stay between 7 and 10 clock cycles. The bench changes rxIn only on falling clock edges and starts every frame pattern with a zero. It keeps glitches inside the first half of a zero cell. After the last cell it leaves the line quiet for longer than the timeout, so every frame closes before the next one begins.

// File: rtl/bmcdec_pkg.sv
package bmcdec_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic sample;     // take the line level at the sample phase
    logic first;      // this sample is the frame's reference bit
  } bmcCtl_t;

endpackage

// File: rtl/bmc_dec_datapath.sv
module bmc_dec_datapath
  import bmcdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxIn,
  input  bmcCtl_t ctl,
  output logic    lineEdge,
  output logic    dataOut,
  output logic    clkStrobe
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic lineNow;
  logic lineDly;
  logic refLevel;
  logic sampleDly;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= rxIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxIn};
      end
    end
  endgenerate

  assign lineNow  = syncReg[SYNC_STAGES-1];
  assign lineEdge = lineNow ^ lineDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineDly   <= 1'b0;
      refLevel  <= 1'b0;
      dataOut   <= 1'b0;
      sampleDly <= 1'b0;
      clkStrobe <= 1'b0;
    end else begin
      lineDly   <= lineNow;
      sampleDly <= ctl.sample;
      clkStrobe <= sampleDly;
      if (ctl.sample) begin
        refLevel <= lineNow;
        dataOut  <= ctl.first ? 1'b0 : (lineNow == refLevel);
      end
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.sample) |-> $stable(dataOut));

  // R3
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkStrobe |-> $past(ctl.sample, 2));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkStrobe |=> !clkStrobe);

endmodule

// File: rtl/bmc_dec_control.sv
module bmc_dec_control
  import bmcdec_pkg::*;
#(
  parameter int OVERSAMPLE    = 8,
  parameter int SAMPLE_PHASE  = 5,
  parameter int STALL_PERIODS = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineEdge,
  output bmcCtl_t ctl,
  output logic    frameSelN
);

  localparam int CNT_W      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int LAST_PHASE = OVERSAMPLE - 1;
  localparam int TIMEOUT    = STALL_PERIODS * OVERSAMPLE;
  localparam int SIL_W      = $clog2(TIMEOUT + 1);

  logic             active;
  logic [CNT_W-1:0] phase;
  logic             armed;
  logic [SIL_W-1:0] silence;
  logic             firstBit;

  logic atLast, atSample, validEdge, timeoutHit, sampleNow;

  assign atLast     = (phase == CNT_W'(LAST_PHASE));
  assign atSample   = (phase == CNT_W'(SAMPLE_PHASE));
  assign validEdge  = active && lineEdge && armed;
  assign timeoutHit = active && atLast && !validEdge &&
                      (silence == SIL_W'(TIMEOUT - 1));
  assign sampleNow  = active && atSample && !validEdge;

  assign ctl.sample = sampleNow;
  assign ctl.first  = firstBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phase     <= '0;
      armed     <= 1'b0;
      silence   <= '0;
      frameSelN <= 1'b1;
      firstBit  <= 1'b0;
    end else if (!active) begin
      if (lineEdge) begin
        active    <= 1'b1;
        phase     <= '0;
        armed     <= 1'b0;
        silence   <= '0;
        frameSelN <= 1'b0;
        firstBit  <= 1'b1;
      end
    end else if (timeoutHit) begin
      active    <= 1'b0;
      phase     <= '0;
      armed     <= 1'b0;
      silence   <= '0;
      frameSelN <= 1'b1;
    end else if (validEdge) begin
      phase   <= '0;
      armed   <= 1'b0;
      silence <= '0;
    end else begin
      if (!atLast) phase   <= phase + CNT_W'(1);
      else         silence <= silence + SIL_W'(1);
      if (atSample) armed    <= 1'b1;
      if (sampleNow) firstBit <= 1'b0;
    end
  end

  // R2
  start_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameSelN) |-> (phase == '0) && !armed);

  // R6
  restart_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && phase == '0 && $past(phase) != '0) |-> $past(armed));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && atLast && !lineEdge && !timeoutHit) |=> atLast);

  // R8
  timeout_from_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSelN) |-> $past(phase) == CNT_W'(LAST_PHASE));

endmodule

// File: rtl/bmc_line_decoder.sv
module bmc_line_decoder
  import bmcdec_pkg::*;
#(
  parameter int OVERSAMPLE    = 8,
  parameter int SAMPLE_PHASE  = 5,
  parameter int STALL_PERIODS = 7,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic dataOut,
  output logic clkStrobe,
  output logic frameSelN
);

  bmcCtl_t ctl;
  logic    lineEdge;

  bmc_dec_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .ctl      (ctl),
    .lineEdge (lineEdge),
    .dataOut  (dataOut),
    .clkStrobe(clkStrobe)
  );

  bmc_dec_control #(
    .OVERSAMPLE   (OVERSAMPLE),
    .SAMPLE_PHASE (SAMPLE_PHASE),
    .STALL_PERIODS(STALL_PERIODS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineEdge (lineEdge),
    .ctl      (ctl),
    .frameSelN(frameSelN)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSelN && $past(frameSelN)) |-> !clkStrobe);

endmodule

// File: tb/tb_bmc_line_decoder.sv
`timescale 1ns/1ps
module tb_bmc_line_decoder;

  localparam int STROBE_OFS = 10;
  localparam int START_OFS  = 3;
  localparam int END_OFS    = 66;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b0;
  logic dataOut, clkStrobe, frameSelN;

  int checks = 0;
  int fails  = 0;
  int cycCnt = 0;

  logic gotBit [0:127];
  int   gotCyc [0:127];
  int   gotN = 0;
  int   bnd [0:127];
  int   riseCyc = -1;
  int   fallCyc = -1;
  logic prevSel = 1'b1;

  bmc_line_decoder dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn),
    .dataOut(dataOut), .clkStrobe(clkStrobe), .frameSelN(frameSelN)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  always @(negedge clk) begin
    if (clkStrobe && gotN < 128) begin
      gotBit[gotN] = dataOut;
      gotCyc[gotN] = cycCnt;
      gotN = gotN + 1;
    end
    if (frameSelN && !prevSel) riseCyc = cycCnt;
    if (!frameSelN && prevSel) fallCyc = cycCnt;
    prevSel = frameSelN;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // one cell: boundary toggle, optional mid toggle, optional early glitch pair
  task automatic sendCell(input int idx, input logic val, input int per,
                          input int mid, input logic glitch);
    @(negedge clk);
    rxIn = ~rxIn;
    bnd[idx] = cycCnt;
    for (int i = 1; i < per; i++) begin
      @(negedge clk);
      if (val && i == mid) rxIn = ~rxIn;
      if (glitch && !val && (i == 2 || i == 3)) rxIn = ~rxIn;
    end
  endtask

  task automatic runFrame(input string tag, input logic [63:0] pat, input int n,
                          input int per, input int mid, input logic glitch);
    int startN;
    startN = gotN;
    riseCyc = -1;
    fallCyc = -1;
    for (int k = 0; k < n; k++) sendCell(k, pat[k], per, mid, glitch);
    repeat (END_OFS + 20) @(negedge clk);
    chk({tag, " R3 strobe count"}, gotN - startN, n);
    chk({tag, " R2 frame start"}, fallCyc, bnd[0] + START_OFS);
    chk({tag, " R8 frame end"}, riseCyc, bnd[n-1] + END_OFS);
    if (gotN - startN == n) begin
      chk({tag, " R4 first bit"}, int'(gotBit[startN]), 0);
      for (int k = 1; k < n; k++)
        chk({tag, " R5 bit"}, int'(gotBit[startN + k]), int'(pat[k]));
      for (int k = 0; k < n; k++)
        chk({tag, " R3 strobe timing"}, gotCyc[startN + k], bnd[k] + STROBE_OFS);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 frameSelN", int'(frameSelN), 1);
    chk("R1 dataOut", int'(dataOut), 0);
    chk("R1 clkStrobe", int'(clkStrobe), 0);
  endtask

  task automatic testIdleQuiet();
    int n0;
    n0 = gotN;
    repeat (100) @(negedge clk);
    chk("R9 no strobe when idle", gotN - n0, 0);
    chk("R9 frameSelN idle", int'(frameSelN), 1);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdleQuiet();
    // nominal 8-cycle cells, mixed pattern
    runFrame("nominal", 64'b1011_0011_1010_0110, 16, 8, 4, 1'b0);
    testIdleQuiet();
    // R9 second frame after end, all ones after the reference
    runFrame("restart", 64'hFFFE, 16, 8, 4, 1'b0);
    // R6 glitch pairs early in zero cells
    runFrame("glitch", 64'b0110_1001_0100_1000, 16, 8, 4, 1'b1);
    // R7 slow sender, R8 silence must not accumulate over 32 cells
    runFrame("slow", 64'h5A3C_96F0, 32, 10, 5, 1'b0);
    // R7 fast sender
    runFrame("fast", 64'b1100_1010_0111_0010, 16, 7, 3, 1'b0);
    // R5 alternating zeros only
    runFrame("zeros", 64'h0, 12, 8, 4, 1'b0);
    testIdleQuiet();
    summary();
  end

endmodule